// File: doc/BRIEF.md
# Interrupt Source Coalescing State Array

This block keeps a two-bit pending/queued state for each hardware interrupt source. It decides, for every incoming trigger pulse, whether the event is passed on to the routing stage or folded into an earlier one. A source that is idle forwards its first trigger and becomes pending. Further triggers while pending are remembered once as queued and do not forward. A masked source absorbs everything.

Software manages the sources through a small register port with a valid/ready request and a one-cycle read response. A store to a source is its end-of-interrupt. It clears the pending state and, if a trigger was queued meanwhile, replays exactly one notification. Loads either peek at the state or return the old value while forcing a new one, which is how sources are armed, masked and reset.

Forwarded events become source-index notifications on a valid/ready output. Each forwarding source marks a per-source waiting bit. The lowest waiting index is moved into a small FIFO each cycle, so a stalled consumer loses nothing.

Top module: `pq_event_gate`

## Requirements
- R1: After reset every source state is masked (P=0, Q=1, read as 2'b01), `ntf_valid_o` is low and `req_ready_o` is high from the second cycle after reset release.
- R2: A trigger on a source in state 2'b00 moves it to 2'b10 and produces one notification whose `ntf_src_o` equals the source index.
- R3: A trigger on a source in state 2'b10 moves it to 2'b11, and a trigger in state 2'b11 leaves it at 2'b11; neither produces a notification.
- R4: A trigger on a masked source (2'b01) leaves the state at 2'b01 and produces no notification.
- R5: An accepted load with `req_off_i[2]`=0 returns the source state in `rsp_data_o` (P in bit 1, Q in bit 0) with `rsp_valid_o` high in the next cycle, and leaves the state unchanged.
- R6: An accepted load with `req_off_i[2]`=1 returns the state held before the access and sets the state to `req_off_i[1:0]`, without producing a notification.
- R7: An accepted store is an end-of-interrupt. From 2'b10 it gives 2'b00 with no notification. From 2'b11 it gives 2'b10 and one notification. 2'b00 and the masked 2'b01 are left unchanged with no notification. A store raises no read response.
- R8: When a register access and a trigger hit the same source in one cycle, the access is applied first and the trigger acts on its result; a load returns the state before both.
- R9: Every forwarded event yields exactly one notification even while `ntf_ready_i` is low. A presented notification keeps `ntf_valid_o` high and `ntf_src_o` unchanged until accepted.
- R10: When several sources wait for delivery, they enter the output queue lowest source index first and leave in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_SRC | One trigger pulse bit per source |
| req_valid_i | input | 1 | Register access request |
| req_ready_o | output | 1 | Register port accepts requests |
| req_write_i | input | 1 | 1 = store (end-of-interrupt), 0 = load |
| req_src_i | input | IDX_W | Source addressed by the access |
| req_off_i | input | 3 | Load offset: bit 2 selects set, bits 1:0 the new state |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_data_o | output | 2 | Source state before the load (P bit 1, Q bit 0) |
| ntf_valid_o | output | 1 | Notification available |
| ntf_ready_i | input | 1 | Consumer accepts the notification |
| ntf_src_o | output | IDX_W | Source index of the notification |

## Verification
The assertions rely on software never re-arming or ending a source whose earlier notification is still undelivered. Under that rule no source can forward twice while its waiting bit is set, so waiting bits never merge. The stimulus follows the rule by keeping a per-source count of forwarded versus received notifications. Any state-changing access aimed at a source with an outstanding notification is turned into a plain peek. Triggers, peeks and consumer stalls stay unrestricted, so coalescing, same-cycle collisions and backpressure are still covered.

// File: rtl/pq_gate_pkg.sv
package pq_gate_pkg;

    typedef enum logic [1:0] {
        PQ_IDLE   = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_e;

    typedef struct packed {
        logic fwd;
        pq_e  nxt;
    } pq_step_t;

    // Hardware trigger applied to a state
    function automatic pq_step_t pq_trigger(input pq_e s);
        pq_step_t r;
        r.fwd = 1'b0;
        r.nxt = s;
        case (s)
            PQ_IDLE:   begin r.fwd = 1'b1; r.nxt = PQ_PEND; end
            PQ_PEND:   r.nxt = PQ_QUEUED;
            PQ_QUEUED: r.nxt = PQ_QUEUED;
            default:   r.nxt = PQ_OFF;
        endcase
        return r;
    endfunction

    // Register access: store = end-of-interrupt, load may force a state
    function automatic pq_step_t pq_access(input pq_e s, input logic wr,
                                           input logic [2:0] off);
        pq_step_t r;
        r.fwd = 1'b0;
        r.nxt = s;
        if (wr) begin
            case (s)
                PQ_PEND:   r.nxt = PQ_IDLE;
                PQ_QUEUED: begin r.fwd = 1'b1; r.nxt = PQ_PEND; end
                default:   r.nxt = s;
            endcase
        end else if (off[2]) begin
            r.nxt = pq_e'(off[1:0]);
        end
        return r;
    endfunction

endpackage

// File: rtl/pq_state_array.sv
module pq_state_array
    import pq_gate_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic               op_valid_i,
    input  logic               op_write_i,
    input  logic [IDX_W-1:0]   op_idx_i,
    input  logic [2:0]         op_off_i,
    input  logic               clr_valid_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    output logic [1:0]         rd_data_o,
    output logic [NUM_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0] pq;
        logic [NUM_SRC-1:0]      pend;
    } arr_st_t;

    arr_st_t            st_d, st_q;
    logic [NUM_SRC-1:0] fwd;

    always_comb begin : next_state
        logic     hit;
        logic     clr_hit;
        pq_step_t after_op;
        pq_step_t after_trg;
        st_d = st_q;
        fwd  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            hit     = op_valid_i && (op_idx_i == IDX_W'(i));
            clr_hit = clr_valid_i && (clr_idx_i == IDX_W'(i));
            if (hit) begin
                after_op = pq_access(pq_e'(st_q.pq[i]), op_write_i, op_off_i);
            end else begin
                after_op.fwd = 1'b0;
                after_op.nxt = pq_e'(st_q.pq[i]);
            end
            if (trig_i[i]) begin
                after_trg = pq_trigger(after_op.nxt);
            end else begin
                after_trg.fwd = 1'b0;
                after_trg.nxt = after_op.nxt;
            end
            fwd[i]        = after_op.fwd | after_trg.fwd;
            st_d.pq[i]    = after_trg.nxt;
            st_d.pend[i]  = (st_q.pend[i] & ~clr_hit) | fwd[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pq   <= {NUM_SRC{PQ_OFF}};
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.pq[op_idx_i];
    assign pend_o    = st_q.pend;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_chk
        // R2: a source waits for delivery only after entering a P=1 state
        p_wait_has_p_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.pend[g]) |-> st_q.pq[g][1]);
        // R4: a masked source ignores a trigger
        p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pq[g] == 2'b01 && trig_i[g] &&
             !(op_valid_i && op_idx_i == IDX_W'(g)))
            |=> (st_q.pq[g] == 2'b01 && !$rose(st_q.pend[g])));
        // R9: no second forward while an earlier one still waits
        p_no_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[g] && !(clr_valid_i && clr_idx_i == IDX_W'(g)))
            |-> !fwd[g]);
    end

endmodule

// File: rtl/pq_pick.sv
module pq_pick #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pq_fifo.sv
module pq_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             full_o,
    output logic             valid_o,
    input  logic             ready_i,
    output logic [WIDTH-1:0] data_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        do_pop = (st_q.cnt != '0) && ready_i;
        if (push_i) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr           = ptr_inc(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_i) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign valid_o = (st_q.cnt != '0);
    assign data_o  = st_q.mem[st_q.rd];

    // R9: the queue is never written while full
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R9: a stalled head stays put
    p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

endmodule

// File: rtl/pq_event_gate.sv
module pq_event_gate
    import pq_gate_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int FIFO_DEPTH = 4,
    parameter int IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic               req_write_i,
    input  logic [IDX_W-1:0]   req_src_i,
    input  logic [2:0]         req_off_i,
    output logic               rsp_valid_o,
    output logic [1:0]         rsp_data_o,
    output logic               ntf_valid_o,
    input  logic               ntf_ready_i,
    output logic [IDX_W-1:0]   ntf_src_o
);

    typedef struct packed {
        logic       ready;
        logic       rsp_valid;
        logic [1:0] rsp_data;
    } port_st_t;

    port_st_t           st_d, st_q;
    logic               op_valid;
    logic [1:0]         rd_data;
    logic [NUM_SRC-1:0] pend;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic               fifo_full;
    logic               push;

    assign op_valid = req_valid_i && st_q.ready;
    assign push     = pick_any && !fifo_full;

    pq_state_array #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .op_valid_i  (op_valid),
        .op_write_i  (req_write_i),
        .op_idx_i    (req_src_i),
        .op_off_i    (req_off_i),
        .clr_valid_i (push),
        .clr_idx_i   (pick_idx),
        .rd_data_o   (rd_data),
        .pend_o      (pend)
    );

    pq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req_i (pend),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    pq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(IDX_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (pick_idx),
        .full_o  (fifo_full),
        .valid_o (ntf_valid_o),
        .ready_i (ntf_ready_i),
        .data_o  (ntf_src_o)
    );

    always_comb begin
        st_d           = st_q;
        st_d.ready     = 1'b1;
        st_d.rsp_valid = op_valid && !req_write_i;
        if (op_valid && !req_write_i) begin
            st_d.rsp_data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready_o = st_q.ready;
    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_data_o  = st_q.rsp_data;

    // R5: a response follows an accepted load one cycle later
    p_rsp_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && req_ready_o && !req_write_i));
    // R10: the picked source really waits and none below it does
    p_pick_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> (pend[pick_idx] &&
            ((pend & ((NUM_SRC'(1) << pick_idx) - NUM_SRC'(1))) == '0)));

endmodule

// File: tb/pq_event_gate_tb.sv
`timescale 1ns/1ps
module pq_event_gate_tb_top;

    localparam int NS = 64;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] trig = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [IW-1:0] req_src = '0;
    logic [2:0]    req_off = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_data;
    logic          ntf_valid;
    logic          ntf_ready = 1'b1;
    logic [IW-1:0] ntf_src;

    always #4 clk = ~clk;

    pq_event_gate #(.NUM_SRC(NS), .FIFO_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_src_i(req_src), .req_off_i(req_off),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .ntf_valid_o(ntf_valid), .ntf_ready_i(ntf_ready), .ntf_src_o(ntf_src)
    );

    int         n_chk = 0;
    int         n_err = 0;
    logic [1:0] mdl [NS];
    int         exp_cnt [NS];
    int         rx_cnt [NS];
    int         rx_log [16];
    int         rx_n = 0;
    logic       exp_rv = 1'b0;
    logic [1:0] exp_rd = '0;
    string      exp_tag = "R5";
    logic [1:0] last_rsp = '0;
    logic       stall_prev = 1'b0;
    logic [IW-1:0] stall_src = '0;
    bit         done = 1'b0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [2:0] m_trig(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b110;
            2'b10:   return 3'b011;
            2'b11:   return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [2:0] m_eoi(input logic [1:0] s);
        case (s)
            2'b10:   return 3'b000;
            2'b11:   return 3'b110;
            default: return {1'b0, s};
        endcase
    endfunction

    function automatic logic [2:0] m_load(input logic [1:0] s, input logic [2:0] off);
        return off[2] ? {1'b0, off[1:0]} : {1'b0, s};
    endfunction

    task automatic step(input logic [NS-1:0] tv, input logic rv, input logic rw,
                        input logic [IW-1:0] rs, input logic [2:0] ro, input logic rdy);
        logic [2:0] m;
        logic [2:0] t;
        @(negedge clk);
        if (exp_rv) begin
            check(rsp_valid === 1'b1 && rsp_data === exp_rd, exp_tag, int'(rsp_data), int'(exp_rd));
            last_rsp = rsp_data;
        end
        if (stall_prev) begin
            check(ntf_valid === 1'b1 && ntf_src === stall_src, "R9", int'(ntf_src), int'(stall_src));
        end
        trig = tv; req_valid = rv; req_write = rw; req_src = rs; req_off = ro; ntf_ready = rdy;
        exp_rv = rv && !rw;
        if (rv) begin
            exp_rd  = mdl[rs];
            exp_tag = ro[2] ? "R6" : "R5";
        end
        for (int i = 0; i < NS; i++) begin
            m = {1'b0, mdl[i]};
            if (rv && rs == IW'(i)) m = rw ? m_eoi(mdl[i]) : m_load(mdl[i], ro);
            t = tv[i] ? m_trig(m[1:0]) : {1'b0, m[1:0]};
            mdl[i] = t[1:0];
            exp_cnt[i] += int'(m[2]) + int'(t[2]);
        end
        #1;
        if (ntf_valid && rdy) begin
            rx_cnt[ntf_src]++;
            if (rx_n < 16) rx_log[rx_n] = int'(ntf_src);
            rx_n++;
        end
        stall_prev = ntf_valid && !rdy;
        stall_src  = ntf_src;
    endtask

    task automatic idle(input int n, input logic rdy);
        for (int k = 0; k < n; k++) step('0, 1'b0, 1'b0, '0, 3'b000, rdy);
    endtask

    task automatic acc(input logic w, input int src, input logic [2:0] off);
        step('0, 1'b1, w, IW'(src), off, 1'b1);
    endtask

    task automatic rd(input int src, output logic [1:0] v);
        acc(1'b0, src, 3'b000);
        idle(1, 1'b1);
        v = last_rsp;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [1:0]    v;
        logic [NS-1:0] tv;
        logic          rv, rw, rdy;
        logic [IW-1:0] rs;
        logic [2:0]    ro;
        int            r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) begin mdl[i] = 2'b01; exp_cnt[i] = 0; rx_cnt[i] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle(2, 1'b1);
        // R1: reset state
        check(req_ready === 1'b1, "R1", int'(req_ready), 1);
        check(ntf_valid === 1'b0, "R1", int'(ntf_valid), 0);
        rd(0, v);  check(v == 2'b01, "R1", int'(v), 1);
        rd(63, v); check(v == 2'b01, "R1", int'(v), 1);

        // R6: force source 3 to 00, old value returned
        acc(1'b0, 3, 3'b100); idle(1, 1'b1);
        check(last_rsp == 2'b01, "R6", int'(last_rsp), 1);
        rd(3, v); check(v == 2'b00, "R6", int'(v), 0);

        // R2: first trigger forwards
        rx_n = 0;
        step(NS'(1) << 3, 1'b0, 1'b0, '0, 3'b000, 1'b1); idle(4, 1'b1);
        check(rx_cnt[3] == 1, "R2", rx_cnt[3], 1);
        check(rx_n == 1 && rx_log[0] == 3, "R2", rx_log[0], 3);
        rd(3, v); check(v == 2'b10, "R2", int'(v), 2);

        // R3: later triggers coalesce
        step(NS'(1) << 3, 1'b0, 1'b0, '0, 3'b000, 1'b1);
        step(NS'(1) << 3, 1'b0, 1'b0, '0, 3'b000, 1'b1); idle(4, 1'b1);
        rd(3, v); check(v == 2'b11, "R3", int'(v), 3);
        check(rx_cnt[3] == 1, "R3", rx_cnt[3], 1);

        // R7: end-of-interrupt sequence
        acc(1'b1, 3, 3'b000); idle(4, 1'b1);
        check(rx_cnt[3] == 2, "R7", rx_cnt[3], 2);
        rd(3, v); check(v == 2'b10, "R7", int'(v), 2);
        acc(1'b1, 3, 3'b000); idle(3, 1'b1);
        rd(3, v); check(v == 2'b00, "R7", int'(v), 0);
        acc(1'b1, 3, 3'b000); idle(3, 1'b1);
        rd(3, v); check(v == 2'b00, "R7", int'(v), 0);
        acc(1'b0, 3, 3'b101); acc(1'b1, 3, 3'b000); idle(3, 1'b1);
        rd(3, v); check(v == 2'b01, "R7", int'(v), 1);
        check(rx_cnt[3] == 2, "R7", rx_cnt[3], 2);

        // R4: masked source ignores triggers
        step(NS'(1) << 7, 1'b0, 1'b0, '0, 3'b000, 1'b1); idle(4, 1'b1);
        rd(7, v); check(v == 2'b01, "R4", int'(v), 1);
        check(rx_cnt[7] == 0, "R4", rx_cnt[7], 0);

        // R8: same-cycle access and trigger
        step(NS'(1) << 10, 1'b1, 1'b0, IW'(10), 3'b100, 1'b1); idle(1, 1'b1);
        check(last_rsp == 2'b01, "R8", int'(last_rsp), 1);
        idle(3, 1'b1);
        rd(10, v); check(v == 2'b10, "R8", int'(v), 2);
        check(rx_cnt[10] == 1, "R8", rx_cnt[10], 1);

        // R10: order under stall, R9: stability under stall
        step('0, 1'b1, 1'b0, IW'(5), 3'b100, 1'b0);
        step('0, 1'b1, 1'b0, IW'(2), 3'b100, 1'b0);
        step('0, 1'b1, 1'b0, IW'(9), 3'b100, 1'b0);
        tv = (NS'(1) << 2) | (NS'(1) << 5) | (NS'(1) << 9);
        step(tv, 1'b0, 1'b0, '0, 3'b000, 1'b0);
        idle(6, 1'b0);
        rx_n = 0;
        idle(8, 1'b1);
        check(rx_n == 3, "R10", rx_n, 3);
        check(rx_log[0] == 2, "R10", rx_log[0], 2);
        check(rx_log[1] == 5, "R10", rx_log[1], 5);
        check(rx_log[2] == 9, "R10", rx_log[2], 9);

        // Random phase (R2..R9)
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < NS; i++) tv[i] = ($urandom % 24) == 0;
            rdy = ($urandom % 4) != 0;
            rv  = ($urandom % 2) == 0;
            rs  = IW'($urandom % NS);
            r   = int'($urandom % 8);
            rw  = 1'b0;
            ro  = 3'($urandom % 4);
            if (r >= 3 && r <= 4) ro = 3'b100 | 3'($urandom % 4);
            if (r >= 5) rw = 1'b1;
            if ((rw || ro[2]) && exp_cnt[rs] != rx_cnt[rs]) begin
                rw = 1'b0;
                ro = 3'b000;
            end
            step(tv, rv, rw, rs, ro, rdy);
        end
        idle(40, 1'b1);
        for (int i = 0; i < NS; i++) begin
            check(rx_cnt[i] == exp_cnt[i], "R9", rx_cnt[i], exp_cnt[i]);
        end
        check(ntf_valid === 1'b0, "R9", int'(ntf_valid), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule